// File: doc/BRIEF.md
# UART receive event controller

This block sits behind a UART byte receiver and in front of a consumer. Every byte the receiver delivers goes into a receive FIFO. The block then raises a stream of ordered events that tell the consumer how many newly arrived bytes it may read from the FIFO's read port.

Data is announced in two cases:
- The count of unannounced bytes reaches a programmable fill threshold.
- The line has stayed quiet for a programmable number of symbol times while unannounced bytes remain.

A line break produces a break event. Its size field carries every byte that arrived before the break and has not yet been announced, so no byte is stranded in the FIFO. Bytes that arrive after the break count toward the next event. Framing errors and FIFO overflow produce error events, and error events win over other pending work.

Events leave through a valid/ready output that holds each event until the consumer accepts it. While an event waits, new conditions are latched and issued later in priority order. The bytes themselves are read in arrival order through a simple read-enable port.

Top module: `uart_rx_event_ctrl`

## Requirements
- R1: After reset, `evt_valid` is 0 and `rd_avail` is 0.
- R2: A data event (`evt_type` = 0) is raised once the unannounced byte count reaches `cfg_full_thresh`. Its size is that count. A threshold of 0 behaves as 1.
- R3: When `cfg_idle_syms` symbol ticks pass with no byte and unannounced bytes remain, a data event carries all of them. With nothing unannounced, no event is raised.
- R4: A `rx_break` strobe yields a break event (`evt_type` = 1). Its size is the number of unannounced bytes that arrived before it, including a byte strobed in the same cycle. A break with nothing pending has size 0. Later bytes go to the next event.
- R5: Events are ordered with the byte stream. Data and break sizes add up exactly to the bytes accepted, and every break event is sized as if it closed the stream at the moment it occurred.
- R6: When several conditions wait, the block issues one event at a time, in this order: error, break, threshold, idle timeout.
- R7: A byte arriving while the FIFO is full is dropped. It raises an error event with `evt_ovf` = 1 and is never counted in any event size.
- R8: A `rx_frame_err` strobe raises an error event (`evt_type` = 2) with size 0 and `evt_ovf` = 0.
- R9: While `evt_valid` is high and `evt_ready` is low, the event and all its fields stay unchanged.
- R10: Bytes leave the read port in arrival order. `rd_data` shows the oldest byte whenever `rd_avail` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_tick | input | 1 | One pulse per symbol time, used for idle timing |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_frame_err | input | 1 | Framing error strobe |
| rx_break | input | 1 | Line break strobe |
| cfg_full_thresh | input | 8 | Fill threshold for data events (0 acts as 1) |
| cfg_idle_syms | input | 8 | Idle symbol times before a timeout event (0 acts as 1) |
| evt_valid | output | 1 | Event present |
| evt_ready | input | 1 | Consumer accepts the event |
| evt_type | output | 2 | 0 data, 1 break, 2 error |
| evt_size | output | 8 | Bytes announced by this event |
| evt_ovf | output | 1 | Error event caused by overflow |
| rd_en | input | 1 | Pop one byte from the FIFO |
| rd_data | output | 8 | Oldest byte in the FIFO |
| rd_avail | output | 1 | FIFO holds at least one byte |

## Verification
A wrong pending count, or a lost break snapshot, shows up at the ports as a mis-sized event. The bench catches this at the very next break event: it compares the break size against the bytes it sent before that break, minus the sizes already accepted. A priority or hold fault shows up within a few cycles, either as a reordered event sequence or as payload movement while the output is stalled. A FIFO pointer fault shows up on the first byte read after it, as a wrong byte value.

// File: rtl/rxev_pkg.sv
package rxev_pkg;

  typedef enum logic [1:0] {
    EV_DATA  = 2'd0,
    EV_BREAK = 2'd1,
    EV_ERROR = 2'd2
  } ev_kind_e;

  // request slots, lowest index wins
  localparam int unsigned REQ_ERR = 0;
  localparam int unsigned REQ_BRK = 1;
  localparam int unsigned REQ_THR = 2;
  localparam int unsigned REQ_TMO = 3;
  localparam int unsigned REQ_N   = 4;

endpackage

// File: rtl/rxev_rst_sync.sv
module rxev_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/rxev_fifo.sv
module rxev_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 128
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [DW-1:0]              wr_data,
  input  logic                       rd_en,
  output logic [DW-1:0]              rd_data,
  output logic [$clog2(DEPTH):0]     level,
  output logic                       full,
  output logic                       empty
);

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_wr, do_rd;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    if (do_wr) wp_n = (wp_q == LAST) ? '0 : wp_q + AW'(1);
    if (do_rd) rp_n = (rp_q == LAST) ? '0 : rp_q + AW'(1);
    cnt_n = cnt_q + CW'(do_wr) - CW'(do_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  // storage carries no reset
  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= wr_data;
  end

  assign rd_data = mem[rp_q];
  assign level   = cnt_q;

endmodule

// File: rtl/rxev_idle_timer.sv
module rxev_idle_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_seen,
  input  logic          sym_tick,
  input  logic [TW-1:0] limit,
  output logic          expired
);

  localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};

  logic [TW-1:0] cnt_q, cnt_n, lim_eff;

  assign lim_eff = (limit == '0) ? TW'(1) : limit;

  always_comb begin
    cnt_n = cnt_q;
    if (byte_seen)                       cnt_n = '0;
    else if (sym_tick && cnt_q != CNT_MAX) cnt_n = cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign expired = (cnt_q >= lim_eff);

endmodule

// File: rtl/rxev_prio.sv
module rxev_prio #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);

  logic taken;

  always_comb begin
    taken = 1'b0;
    gnt   = '0;
    for (int i = 0; i < N; i++) begin
      gnt[i] = req[i] && !taken;
      taken  = taken || req[i];
    end
  end

endmodule

// File: rtl/uart_rx_event_ctrl.sv
module uart_rx_event_ctrl
  import rxev_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned IDLE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sym_tick,
  input  logic                      rx_valid,
  input  logic [DATA_W-1:0]         rx_data,
  input  logic                      rx_frame_err,
  input  logic                      rx_break,
  input  logic [$clog2(DEPTH):0]    cfg_full_thresh,
  input  logic [IDLE_W-1:0]         cfg_idle_syms,
  output logic                      evt_valid,
  input  logic                      evt_ready,
  output logic [1:0]                evt_type,
  output logic [$clog2(DEPTH):0]    evt_size,
  output logic                      evt_ovf,
  input  logic                      rd_en,
  output logic [DATA_W-1:0]         rd_data,
  output logic                      rd_avail
);

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;
  localparam logic [CW-1:0] SIZE_MAX = {CW{1'b1}};

  function automatic logic [CW-1:0] sat_add(input logic [CW-1:0] a, input logic [CW-1:0] b);
    logic [CW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CW] ? SIZE_MAX : s[CW-1:0];
  endfunction

  logic rst_q_n;

  rxev_rst_sync i_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_q_n)
  );

  // ---------------- byte storage ----------------
  logic [CW-1:0] fifo_level;
  logic          fifo_full, fifo_empty;
  logic          acc, drop;

  rxev_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) i_fifo (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .wr_en  (rx_valid),
    .wr_data(rx_data),
    .rd_en  (rd_en),
    .rd_data(rd_data),
    .level  (fifo_level),
    .full   (fifo_full),
    .empty  (fifo_empty)
  );

  assign acc      = rx_valid && !fifo_full;
  assign drop     = rx_valid && fifo_full;
  assign rd_avail = !fifo_empty;

  // ---------------- idle timing ----------------
  logic idle_expired;

  rxev_idle_timer #(.TW(IDLE_W)) i_idle (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .byte_seen(rx_valid),
    .sym_tick (sym_tick),
    .limit    (cfg_idle_syms),
    .expired  (idle_expired)
  );

  // ---------------- pending state ----------------
  logic [CW-1:0] pend_q, pend_n;
  logic          brk_pend_q, brk_pend_n;
  logic [CW-1:0] brk_size_q, brk_size_n;
  logic          err_pend_q, err_pend_n;
  logic          err_ovf_q, err_ovf_n;

  logic [CW-1:0] thr_eff;
  logic          thr_req, tmo_req, slot_free;
  logic [REQ_N-1:0] req_v, req_m, gnt;
  logic          g_err, g_brk, g_dat;

  assign thr_eff   = (cfg_full_thresh == '0) ? CW'(1) : cfg_full_thresh;
  assign thr_req   = (pend_q >= thr_eff);
  assign tmo_req   = (pend_q != '0) && idle_expired;
  assign slot_free = !evt_valid;

  always_comb begin
    req_v          = '0;
    req_v[REQ_ERR] = err_pend_q;
    req_v[REQ_BRK] = brk_pend_q;
    req_v[REQ_THR] = thr_req;
    req_v[REQ_TMO] = tmo_req;
    req_m          = slot_free ? req_v : '0;
  end

  rxev_prio #(.N(REQ_N)) i_prio (
    .req(req_m),
    .gnt(gnt)
  );

  assign g_err = gnt[REQ_ERR];
  assign g_brk = gnt[REQ_BRK];
  assign g_dat = gnt[REQ_THR] || gnt[REQ_TMO];

  logic [CW-1:0] pend_base, avail, brk_keep;

  always_comb begin
    pend_base = g_dat ? '0 : pend_q;
    avail     = sat_add(pend_base, CW'(acc));
    brk_keep  = (brk_pend_q && !g_brk) ? brk_size_q : '0;
    if (rx_break) begin
      // bytes up to and including this cycle close out into the break
      brk_pend_n = 1'b1;
      brk_size_n = sat_add(brk_keep, avail);
      pend_n     = '0;
    end else begin
      brk_pend_n = brk_pend_q && !g_brk;
      brk_size_n = brk_keep;
      pend_n     = avail;
    end
    err_pend_n = (err_pend_q && !g_err) || rx_frame_err || drop;
    err_ovf_n  = (g_err ? 1'b0 : err_ovf_q) || drop;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      pend_q     <= '0;
      brk_pend_q <= 1'b0;
      brk_size_q <= '0;
      err_pend_q <= 1'b0;
      err_ovf_q  <= 1'b0;
    end else begin
      pend_q     <= pend_n;
      brk_pend_q <= brk_pend_n;
      brk_size_q <= brk_size_n;
      err_pend_q <= err_pend_n;
      err_ovf_q  <= err_ovf_n;
    end
  end

  // ---------------- event output register ----------------
  logic          evt_load, evt_valid_n;
  logic [1:0]    type_n;
  logic [CW-1:0] size_n;
  logic          ovf_n;

  assign evt_load = g_err || g_brk || g_dat;

  always_comb begin
    type_n = EV_DATA;
    size_n = pend_q;
    ovf_n  = 1'b0;
    if (g_err) begin
      type_n = EV_ERROR;
      size_n = '0;
      ovf_n  = err_ovf_q;
    end else if (g_brk) begin
      type_n = EV_BREAK;
      size_n = brk_size_q;
    end
    evt_valid_n = evt_valid;
    if (evt_load)                    evt_valid_n = 1'b1;
    else if (evt_valid && evt_ready) evt_valid_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) evt_valid <= 1'b0;
    else          evt_valid <= evt_valid_n;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      evt_type <= EV_DATA;
      evt_size <= '0;
      evt_ovf  <= 1'b0;
    end else if (evt_load) begin
      evt_type <= type_n;
      evt_size <= size_n;
      evt_ovf  <= ovf_n;
    end
  end

endmodule

// File: rtl/rxev_checker.sv
module rxev_checker
  import rxev_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input logic          clk,
  input logic          rst_q_n,
  input logic          evt_valid,
  input logic          evt_ready,
  input logic [1:0]    evt_type,
  input logic [CW-1:0] evt_size,
  input logic          evt_ovf,
  input logic          err_pend_q,
  input logic          brk_pend_q,
  input logic          rx_break,
  input logic          rx_valid,
  input logic          rd_en,
  input logic          fifo_full,
  input logic [CW-1:0] fifo_level
);

  // R9: a stalled event keeps every field
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_q_n)
    evt_valid && !evt_ready |=> evt_valid && $stable(evt_type) && $stable(evt_size) && $stable(evt_ovf));

  // R6: a waiting error goes out first once the slot is free
  a_r6_error_first: assert property (@(posedge clk) disable iff (!rst_q_n)
    !evt_valid && err_pend_q |=> evt_valid && evt_type == EV_ERROR);

  // R6: only the three defined kinds appear
  a_r6_known_kind: assert property (@(posedge clk) disable iff (!rst_q_n)
    evt_valid |-> evt_type != 2'd3);

  // R4: a break strobe is never lost
  a_r4_break_latched: assert property (@(posedge clk) disable iff (!rst_q_n)
    rx_break |=> brk_pend_q);

  // R8: error events announce no bytes
  a_r8_error_size: assert property (@(posedge clk) disable iff (!rst_q_n)
    evt_valid && evt_type == EV_ERROR |-> evt_size == '0);

  // R2, R3: data events never announce zero bytes
  a_r2_data_nonempty: assert property (@(posedge clk) disable iff (!rst_q_n)
    evt_valid && evt_type == EV_DATA |-> evt_size != '0);

  // R7: a byte offered to a full FIFO with no pop leaves the level unchanged
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_q_n)
    rx_valid && fifo_full && !rd_en |=> $stable(fifo_level));

endmodule

bind uart_rx_event_ctrl rxev_checker #(.CW(CW)) i_rxev_checker (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .evt_valid (evt_valid),
  .evt_ready (evt_ready),
  .evt_type  (evt_type),
  .evt_size  (evt_size),
  .evt_ovf   (evt_ovf),
  .err_pend_q(err_pend_q),
  .brk_pend_q(brk_pend_q),
  .rx_break  (rx_break),
  .rx_valid  (rx_valid),
  .rd_en     (rd_en),
  .fifo_full (fifo_full),
  .fifo_level(fifo_level)
);

// File: tb/test_uart_rx_event_ctrl.sv
module test_uart_rx_event_ctrl;
  import rxev_pkg::*;

  localparam int DEPTH = 128;
  localparam int CW    = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sym_tick = 1'b0;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_data = '0;
  logic          rx_frame_err = 1'b0;
  logic          rx_break = 1'b0;
  logic [CW-1:0] cfg_full_thresh = 8'd120;
  logic [7:0]    cfg_idle_syms = 8'd255;
  logic          evt_valid;
  logic          evt_ready = 1'b1;
  logic [1:0]    evt_type;
  logic [CW-1:0] evt_size;
  logic          evt_ovf;
  logic          rd_en = 1'b0;
  logic [7:0]    rd_data;
  logic          rd_avail;

  always #10 clk = ~clk;

  uart_rx_event_ctrl i_uart_rx_event_ctrl (
    .clk(clk), .rst_n(rst_n), .sym_tick(sym_tick),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_frame_err(rx_frame_err), .rx_break(rx_break),
    .cfg_full_thresh(cfg_full_thresh), .cfg_idle_syms(cfg_idle_syms),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_type(evt_type),
    .evt_size(evt_size), .evt_ovf(evt_ovf),
    .rd_en(rd_en), .rd_data(rd_data), .rd_avail(rd_avail)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int n_sent  = 0;
  int n_rep   = 0;
  int rdy_mode = 0;       // 0 always ready, 1 never, 2 random
  bit rd_auto  = 1'b1;
  bit drop_flag = 1'b0;
  bit done = 1'b0;
  int tk = 0;

  logic [7:0] exp_q[$];
  int brk_q[$];
  int ev_t[$];
  int ev_s[$];
  int ev_o[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_ev(input int t, input int s, input int o, input string req);
    n_tests++;
    if (ev_t.size() == 0) begin
      n_fail++;
      $display("FAIL %s: actual no event expected type %0d size %0d ovf %0d", req, t, s, o);
    end else begin
      int at, as, ao;
      at = ev_t.pop_front(); as = ev_s.pop_front(); ao = ev_o.pop_front();
      if (at != t || as != s || ao != o) begin
        n_fail++;
        $display("FAIL %s: actual type %0d size %0d ovf %0d expected type %0d size %0d ovf %0d",
                 req, at, as, ao, t, s, o);
      end
    end
  endtask

  task automatic clear_log();
    ev_t.delete(); ev_s.delete(); ev_o.delete();
  endtask

  task automatic cyc(input bit v, input logic [7:0] b, input bit brk, input bit fe);
    @(negedge clk);
    rx_valid = v; rx_data = b; rx_break = brk; rx_frame_err = fe;
    if (v && !drop_flag) begin
      exp_q.push_back(b);
      n_sent++;
    end
    if (brk) brk_q.push_back(n_sent);
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 1'b0, 1'b0);
  endtask

  // symbol tick every 4 clocks
  always @(negedge clk) begin
    tk = (tk + 1) % 4;
    sym_tick = (tk == 0);
  end

  // event consumer and byte reader
  always @(negedge clk) begin
    bit r;
    if (rst_n) begin
      case (rdy_mode)
        0:       r = 1'b1;
        1:       r = 1'b0;
        default: r = ($urandom % 4) != 0;
      endcase
      evt_ready = r;
      if (evt_valid && r) begin
        ev_t.push_back(int'(evt_type));
        ev_s.push_back(int'(evt_size));
        ev_o.push_back(int'(evt_ovf));
        if (evt_type == EV_BREAK) begin
          if (brk_q.size() == 0) chk(1'b0, "R4 break without strobe", int'(evt_size), -1);
          else begin
            int e;
            e = brk_q.pop_front() - n_rep;
            chk(int'(evt_size) == e, "R4 R5 break size in stream order", int'(evt_size), e);
          end
        end
        if (evt_type != EV_ERROR) n_rep += int'(evt_size);
        chk(n_rep <= n_sent, "R5 announced within sent", n_rep, n_sent);
      end
      if (rd_auto && rd_avail && ($urandom % 4) != 0) begin
        rd_en = 1'b1;
        if (exp_q.size() == 0) chk(1'b0, "R10 read with nothing expected", int'(rd_data), -1);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rd_data == e, "R10 read order", int'(rd_data), int'(e));
        end
      end else begin
        rd_en = 1'b0;
      end
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(evt_valid == 1'b0, "R1 evt_valid after reset", int'(evt_valid), 0);
    chk(rd_avail == 1'b0, "R1 rd_avail after reset", int'(rd_avail), 0);

    // R2 threshold
    clear_log();
    cfg_full_thresh = 8'd4; cfg_idle_syms = 8'd255;
    for (int i = 0; i < 4; i++) cyc(1'b1, 8'(8'h10 + i), 1'b0, 1'b0);
    quiet(10);
    expect_ev(0, 4, 0, "R2 threshold event");
    chk(ev_t.size() == 0, "R2 single event", ev_t.size(), 0);

    // R3 idle timeout
    clear_log();
    cfg_idle_syms = 8'd3;
    for (int i = 0; i < 3; i++) cyc(1'b1, 8'(8'h20 + i), 1'b0, 1'b0);
    quiet(30);
    expect_ev(0, 3, 0, "R3 timeout event");
    quiet(40);
    chk(ev_t.size() == 0, "R3 no event when nothing pending", ev_t.size(), 0);

    // R2 zero threshold acts as one
    clear_log();
    cfg_full_thresh = 8'd0; cfg_idle_syms = 8'd255;
    cyc(1'b1, 8'h31, 1'b0, 1'b0); quiet(4);
    cyc(1'b1, 8'h32, 1'b0, 1'b0); quiet(6);
    expect_ev(0, 1, 0, "R2 zero threshold first");
    expect_ev(0, 1, 0, "R2 zero threshold second");

    // R4 break with same-cycle byte, then bytes after the break
    clear_log();
    cfg_full_thresh = 8'd120;
    for (int i = 0; i < 4; i++) cyc(1'b1, 8'(8'h40 + i), 1'b0, 1'b0);
    cyc(1'b1, 8'h44, 1'b1, 1'b0);
    quiet(8);
    expect_ev(1, 5, 0, "R4 break carries queued bytes");
    cyc(1'b1, 8'h50, 1'b0, 1'b0); cyc(1'b1, 8'h51, 1'b0, 1'b0);
    cfg_idle_syms = 8'd3;
    quiet(30);
    expect_ev(0, 2, 0, "R4 post-break bytes in next event");
    cyc(1'b0, 8'h00, 1'b1, 1'b0); quiet(8);
    expect_ev(1, 0, 0, "R4 empty break");

    // R6 R8 R9 priority behind a stalled output
    clear_log();
    rdy_mode = 1; cfg_full_thresh = 8'd3; cfg_idle_syms = 8'd255;
    for (int i = 0; i < 5; i++) cyc(1'b1, 8'(8'h60 + i), 1'b0, 1'b0);
    cyc(1'b0, 8'h00, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) cyc(1'b1, 8'(8'h70 + i), 1'b0, 1'b0);
    cyc(1'b0, 8'h00, 1'b0, 1'b1);
    quiet(3);
    begin
      logic [1:0] t0; logic [CW-1:0] s0; logic o0;
      t0 = evt_type; s0 = evt_size; o0 = evt_ovf;
      chk(evt_valid == 1'b1, "R9 event held", int'(evt_valid), 1);
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        chk(evt_valid && evt_type == t0 && evt_size == s0 && evt_ovf == o0,
            "R9 fields stable while stalled", int'(evt_size), int'(s0));
      end
    end
    rdy_mode = 0;
    quiet(14);
    expect_ev(0, 3, 0, "R6 held data event first");
    expect_ev(2, 0, 0, "R6 R8 framing error before break");
    expect_ev(1, 2, 0, "R6 break before threshold");
    expect_ev(0, 3, 0, "R6 threshold last");

    // R7 overflow and R10 order
    quiet(20);
    clear_log();
    rd_auto = 1'b0; cfg_full_thresh = 8'd200; cfg_idle_syms = 8'd255;
    quiet(4);
    for (int i = 0; i < DEPTH + 1; i++) begin
      drop_flag = (i >= DEPTH);
      cyc(1'b1, 8'((i * 37 + 5) & 8'hff), 1'b0, 1'b0);
    end
    drop_flag = 1'b0;
    cyc(1'b0, 8'h00, 1'b1, 1'b0);
    quiet(10);
    expect_ev(2, 0, 1, "R7 overflow error event");
    expect_ev(1, DEPTH, 0, "R7 dropped byte not counted");
    rd_auto = 1'b1;
    quiet(400);
    chk(exp_q.size() == 0, "R10 all bytes read in order", exp_q.size(), 0);

    // R5 random stream
    clear_log();
    rdy_mode = 2;
    cfg_full_thresh = 8'(2 + $urandom % 14);
    cfg_idle_syms   = 8'(2 + $urandom % 5);
    begin
      int since_brk;
      since_brk = 0;
      for (int k = 0; k < 4000; k++) begin
        bit v, b, f;
        v = ($urandom % 100) < 40;
        b = (since_brk > 40) && (($urandom % 100) < 3);
        f = ($urandom % 200) == 0;
        since_brk = b ? 0 : since_brk + 1;
        cyc(v, 8'($urandom), b, f);
      end
    end
    rdy_mode = 0; cfg_idle_syms = 8'd2;
    quiet(200);
    chk(n_rep == n_sent, "R5 every byte announced", n_rep, n_sent);
    chk(brk_q.size() == 0, "R4 every break reported", brk_q.size(), 0);
    chk(exp_q.size() == 0, "R10 every byte read", exp_q.size(), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule